// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two 6-bit two's complement operands and returns their 12-bit two's complement product. It is purely combinational. Each pair of multiplier bits, together with the bit below the pair, is recoded into one radix-4 signed digit. Each digit picks a partial-product row of 0, plus or minus the multiplicand, or plus or minus twice the multiplicand. Adjacent rows sit two columns apart.

Negative rows are not formed by a full two's complement negation. The 7-bit row is bit-inverted, and a separate negation carry is added at that row's lowest column.

Rows are not sign-extended across the product width. The top bit of each row is inverted in place. The weight removed by dropping the extension is restored with one precomputed constant made of fixed ones. The rows, the negation carries and that constant are then summed with a plain adder.

The block is meant to sit inside a datapath where a small signed product is needed within one cycle.

Top module: `booth4_mul6`

## Requirements
- R1: For every pair of 6-bit inputs, `prod` equals the two's complement product of `mcand` and `mplier`, truncated to 12 bits.
- R2: When either operand is zero, `prod` is zero.
- R3: The most negative input squared (-32 × -32) gives 0x400. The pair -32 × 31 gives 0xC20 (-992).
- R4: A multiplier of +1 returns the sign-extended multiplicand. A multiplier of -1 (0x3F) returns its negation.
- R5: A multiplier of -32 (0x20) yields a top digit of -2 and zero digits below it. The result is -32 times the multiplicand.
- R6: Bit 0 of `prod` equals the AND of bit 0 of both operands.
- R7: A multiplicand of -32 gives a correct product for every multiplier value. This requires that twice the multiplicand fit in the 7-bit row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | 6 | Multiplicand, two's complement |
| mplier | input | 6 | Multiplier, two's complement, Booth-recoded |
| prod | output | 12 | Product, two's complement |

## Verification
The assertions are immediate checks on settled combinational values. They take for granted that both operands are stable, known values whenever they are evaluated, with no X or Z bits on `mcand` or `mplier`.

The stimulus respects this. The bench changes inputs only on the falling clock edge, to fully defined values, and compares two nanoseconds later. It covers the whole input space exhaustively, adds seeded random pairs, and directs the most negative operand and zero into both inputs.

// File: rtl/booth4_mul6.sv
module booth4_mul6 #(
  parameter int W = 6
) (
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] prod
);
  localparam int ROWS = W / 2;
  localparam int PW   = 2 * W;
  localparam int RW   = W + 1;

  function automatic logic [PW-1:0] comp_const();
    logic [PW-1:0] c;
    c = '0;
    for (int i = 0; i < ROWS; i++) c = c - (PW'(1) << (2 * i + W));
    return c;
  endfunction

  localparam logic [PW-1:0] COMP = comp_const();

  logic [W:0]    yext;
  logic [RW-1:0] x1, x2;
  logic [PW-1:0] term [ROWS];
  logic [ROWS-1:0] neg;

  assign yext = {mplier, 1'b0};
  assign x1   = {mcand[W-1], mcand};
  assign x2   = {mcand, 1'b0};

  for (genvar gi = 0; gi < ROWS; gi++) begin : g_row
    logic [2:0]    trip;
    logic [RW-1:0] mag, r;
    logic          n;
    assign trip = yext[2*gi+2 : 2*gi];
    always_comb begin
      case (trip)
        3'b001, 3'b010: begin mag = x1; n = 1'b0; end
        3'b011:         begin mag = x2; n = 1'b0; end
        3'b100:         begin mag = x2; n = 1'b1; end
        3'b101, 3'b110: begin mag = x1; n = 1'b1; end
        default:        begin mag = '0; n = 1'b0; end
      endcase
    end
    assign r        = n ? ~mag : mag;
    assign neg[gi]  = n;
    assign term[gi] = {{(PW-RW){1'b0}}, ~r[RW-1], r[RW-2:0]} << (2 * gi);
  end

  always_comb begin
    prod = COMP;
    for (int i = 0; i < ROWS; i++)
      prod = prod + term[i] + (PW'(neg[i]) << (2 * i));
  end
endmodule

module booth4_mul6_chk #(
  parameter int W = 6
) (
  input logic [W-1:0]   a,
  input logic [W-1:0]   b,
  input logic [2*W-1:0] p
);
  logic signed [2*W-1:0] ref_p;
  assign ref_p = $signed(a) * $signed(b);

  always_comb begin
    // R1
    product_value_chk: assert (p == ref_p)
      else $error("product mismatch");
    // R2
    zero_operand_chk: assert (!((a == '0) || (b == '0)) || (p == '0))
      else $error("zero operand gave nonzero product");
    // R6
    lsb_parity_chk: assert (p[0] == (a[0] & b[0]))
      else $error("product lsb wrong");
    // R4
    unity_chk: assert (!(b == W'(1)) || (p == {{W{a[W-1]}}, a}))
      else $error("multiplier one wrong");
    // R4
    neg_one_chk: assert (!(b == '1) || (p == -{{W{a[W-1]}}, a}))
      else $error("multiplier minus one wrong");
  end
endmodule

bind booth4_mul6 booth4_mul6_chk #(.W(W)) chk_i (.a(mcand), .b(mplier), .p(prod));

// File: tb/booth4_mul6_tb_top.sv
module booth4_mul6_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  mcand = '0, mplier = '0;
  logic [11:0] prod;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  booth4_mul6 dut_i (.mcand(mcand), .mplier(mplier), .prod(prod));

  function automatic logic [11:0] ref_mul(logic [5:0] a, logic [5:0] b);
    logic signed [11:0] r;
    r = $signed(a) * $signed(b);
    return r;
  endfunction

  task automatic apply(logic [5:0] a, logic [5:0] b, logic [11:0] exp, string req);
    @(negedge clk);
    mcand = a; mplier = b;
    #2;
    checks++;
    if (prod !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, a, b, prod, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [5:0] ra, rb;
    seed = 17;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (prod !== 12'h000) begin
      fails++;
      $display("FAIL R2 reset-state actual=%h expected=000", prod);
    end
    apply(6'h20, 6'h20, 12'h400, "R3");
    apply(6'h20, 6'h1F, 12'hC20, "R3");
    apply(6'h1F, 6'h20, 12'hC20, "R3");
    apply(6'h1F, 6'h1F, 12'h3C1, "R1");
    for (int v = 0; v < 64; v++) begin
      apply(6'(v), 6'h00, 12'h000, "R2");
      apply(6'h00, 6'(v), 12'h000, "R2");
      apply(6'(v), 6'h01, {{6{v[5]}}, 6'(v)}, "R4");
      apply(6'(v), 6'h3F, -{{6{v[5]}}, 6'(v)}, "R4");
      apply(6'(v), 6'h20, ref_mul(6'(v), 6'h20), "R5");
      apply(6'h20, 6'(v), ref_mul(6'h20, 6'(v)), "R7");
    end
    for (int i = 0; i < 64; i++)
      for (int j = 0; j < 64; j++)
        apply(6'(i), 6'(j), ref_mul(6'(i), 6'(j)), "R1");
    for (int k = 0; k < 500; k++) begin
      ra = 6'($urandom);
      rb = 6'($urandom);
      apply(ra, rb, ref_mul(ra, rb), "R1");
      @(negedge clk);
      #2;
      checks++;
      if (prod[0] !== (ra[0] & rb[0])) begin
        fails++;
        $display("FAIL R6 actual=%b expected=%b", prod[0], ra[0] & rb[0]);
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule